// File: doc/BRIEF.md
# Transition-Triggered Timestamped Sampler

This block watches a small group of slow digital inputs (push buttons, slide switches, header pins) on a dedicated sampling clock. When a start pulse arrives it opens a recording window of fixed length. The window lasts about five seconds at the default 6.25 MHz sampling rate. During the window, a record is pushed into a downstream FIFO only in a cycle where the synchronised inputs differ from the previous sample. Each record joins a timestamp with the current input levels.

Each record places the timestamp in its upper bits and the input levels in its low bits. With the default sizes this is a 25-bit count above 7 input bits, which makes a 32-bit word. The timestamp counts sampling cycles from the start of the window and wraps on overflow. With the default sizes it wraps after about 5.4 seconds. Contact bounce is not filtered, so a noisy press appears as a burst of records. The write side of the FIFO runs on the sampling clock. When the FIFO reports full, the record is dropped and a sticky flag is raised.

Top module: `edge_logger`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `active_o`, `fifo_we_o` and `overflow_o` are low.
- R2: A `start_i` pulse sampled while idle raises `active_o` at that edge. `active_o` stays high for exactly `WIN_LEN` sampling cycles and then falls.
- R3: On the edge after a recording starts, one record is written holding timestamp 0 and the current synchronised input levels.
- R4: Each record is `{timestamp, inputs}`, with the timestamp in bits [REC_W-1:IN_W] and the inputs in bits [IN_W-1:0]. An input change that is stable before edge p is written at edge p+2, which is three edges after the change is driven.
- R5: While the inputs stay stable, no record is written.
- R6: Every transition is recorded, including changes that last only one sampling cycle (contact bounce).
- R7: The timestamp of a record written k edges after the start edge equals (k-1) modulo 2^TS_W.
- R8: A `start_i` pulse during an active window is ignored: no extra record is written, and neither the timestamp nor the window length is restarted.
- R9: When `fifo_full_i` is high in the cycle before a record would be written, the record is dropped and `overflow_o` goes high. `overflow_o` then stays high until reset.
- R10: Outside the recording window, input changes write no records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse, sampling domain |
| pins_i | input | IN_W | Asynchronous digital inputs |
| fifo_full_i | input | 1 | FIFO full indication |
| fifo_we_o | output | 1 | FIFO write enable (registered) |
| fifo_data_o | output | TS_W+IN_W | Record: timestamp above input levels |
| active_o | output | 1 | High for the whole recording window |
| overflow_o | output | 1 | Sticky flag: a record was dropped |

## Verification
The bench builds the block with IN_W=7, TS_W=8 and WIN_LEN=400. This keeps the 7-bit input field unchanged while making the timestamp wrap after 256 cycles. As a result, the bench can reach both the wrap and the end of the window within a single short recording. It can also open a second window once the first has closed and confirm that the timestamp restarts at zero.

// File: rtl/edge_logger_pkg.sv
package edge_logger_pkg;
  localparam int unsigned DEF_IN_W    = 7;
  localparam int unsigned DEF_TS_W    = 25;
  localparam int unsigned DEF_WIN_LEN = 31_250_000;
endpackage

// File: rtl/edge_logger_sync.sv
module edge_logger_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        stab_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= d_i[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/edge_logger_window.sv
module edge_logger_window #(
  parameter int unsigned TS_W    = 25,
  parameter int unsigned WIN_LEN = 31_250_000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  output logic            active_o,
  output logic            launch_o,
  output logic [TS_W-1:0] ts_o
);
  localparam int unsigned WIN_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

  logic             active_q, launch_q;
  logic [TS_W-1:0]  ts_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      launch_q <= 1'b0;
      ts_q     <= '0;
      win_q    <= '0;
    end else if (!active_q) begin
      launch_q <= start_i;
      if (start_i) begin
        active_q <= 1'b1;
        ts_q     <= '0;
        win_q    <= '0;
      end
    end else begin
      launch_q <= 1'b0;
      ts_q     <= ts_q + 1'b1;
      win_q    <= win_q + 1'b1;
      if (win_q == WIN_LAST) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign launch_o = launch_q;
  assign ts_o     = ts_q;

  // R7: timestamp advances by one per cycle inside a window
  p_ts_step_r7: assert property (@(posedge clk) disable iff (rst)
    (active_q && $past(active_q)) |-> ts_q == TS_W'($past(ts_q) + 1'b1));
  // R8: a start during a window does not restart the window counter
  p_restart_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (active_q && $past(active_q)) |-> win_q != '0);
  // R2: window counter stays inside the window length
  p_win_bound_r2: assert property (@(posedge clk) disable iff (rst)
    active_q |-> win_q <= WIN_LAST);
endmodule

// File: rtl/edge_logger_emit.sv
module edge_logger_emit #(
  parameter int unsigned IN_W = 7,
  parameter int unsigned TS_W = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active_i,
  input  logic                 launch_i,
  input  logic [TS_W-1:0]      ts_i,
  input  logic [IN_W-1:0]      samp_i,
  input  logic                 full_i,
  output logic                 we_o,
  output logic [TS_W+IN_W-1:0] data_o,
  output logic                 ovf_o
);
  logic [IN_W-1:0]      prev_q;
  logic                 we_q, ovf_q, want;
  logic [TS_W+IN_W-1:0] data_q;

  assign want = active_i && (launch_i || (samp_i != prev_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      we_q   <= 1'b0;
      ovf_q  <= 1'b0;
      data_q <= '0;
    end else begin
      prev_q <= samp_i;
      we_q   <= want && !full_i;
      if (want && !full_i) data_q <= {ts_i, samp_i};
      if (want && full_i)  ovf_q  <= 1'b1;
    end
  end

  assign we_o   = we_q;
  assign data_o = data_q;
  assign ovf_o  = ovf_q;

  // R9: no write is issued against a full FIFO
  p_no_write_full_r9: assert property (@(posedge clk) disable iff (rst)
    we_q |-> !$past(full_i));
  // R9: overflow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  // R10: writes only come from cycles inside the window
  p_we_in_window_r10: assert property (@(posedge clk) disable iff (rst)
    we_q |-> $past(active_i));
  // R3: the launch cycle always produces a write or an overflow
  p_first_rec_r3: assert property (@(posedge clk) disable iff (rst)
    (launch_i && active_i) |=> (we_q || ovf_q));
endmodule

// File: rtl/edge_logger.sv
module edge_logger
  import edge_logger_pkg::*;
#(
  parameter int unsigned IN_W    = DEF_IN_W,
  parameter int unsigned TS_W    = DEF_TS_W,
  parameter int unsigned WIN_LEN = DEF_WIN_LEN
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [IN_W-1:0]      pins_i,
  input  logic                 fifo_full_i,
  output logic                 fifo_we_o,
  output logic [TS_W+IN_W-1:0] fifo_data_o,
  output logic                 active_o,
  output logic                 overflow_o
);
  logic [IN_W-1:0] samp;
  logic            active, launch;
  logic [TS_W-1:0] ts;

  edge_logger_sync #(.W(IN_W)) u_sync (
    .clk(clk), .rst(rst), .d_i(pins_i), .q_o(samp)
  );

  edge_logger_window #(.TS_W(TS_W), .WIN_LEN(WIN_LEN)) u_window (
    .clk(clk), .rst(rst), .start_i(start_i),
    .active_o(active), .launch_o(launch), .ts_o(ts)
  );

  edge_logger_emit #(.IN_W(IN_W), .TS_W(TS_W)) u_emit (
    .clk(clk), .rst(rst), .active_i(active), .launch_i(launch),
    .ts_i(ts), .samp_i(samp), .full_i(fifo_full_i),
    .we_o(fifo_we_o), .data_o(fifo_data_o), .ovf_o(overflow_o)
  );

  assign active_o = active;
endmodule

// File: tb/edge_logger_bench.sv
module edge_logger_bench;
  localparam int IN_W = 7;
  localparam int TS_W = 8;
  localparam int WIN_LEN = 400;
  localparam int REC_W = IN_W + TS_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [IN_W-1:0] pins_i = '0;
  logic fifo_full_i = 1'b0;
  logic fifo_we_o, active_o, overflow_o;
  logic [REC_W-1:0] fifo_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int c0 = 0;
  int rec_tot = 0;
  logic [REC_W-1:0] rec_data [0:255];
  int rec_cyc [0:255];

  edge_logger #(.IN_W(IN_W), .TS_W(TS_W), .WIN_LEN(WIN_LEN)) u_edge_logger (
    .clk(clk), .rst(rst), .start_i(start_i), .pins_i(pins_i),
    .fifo_full_i(fifo_full_i), .fifo_we_o(fifo_we_o),
    .fifo_data_o(fifo_data_o), .active_o(active_o), .overflow_o(overflow_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && fifo_we_o) begin
      rec_data[rec_tot[7:0]] <= fifo_data_o;
      rec_cyc[rec_tot[7:0]]  <= cyc;
      rec_tot <= rec_tot + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_ts(input int c);
    return (c - c0 - 1) % (1 << TS_W);
  endfunction

  // check one record at index idx against cycle and pins
  task automatic chk_rec(input int idx, input string req, input int ecyc,
                         input logic [IN_W-1:0] epins);
    chk(rec_cyc[idx[7:0]] == ecyc, req, "record cycle", rec_cyc[idx[7:0]], ecyc);
    chk(int'(rec_data[idx[7:0]][IN_W-1:0]) == int'(epins), req, "record inputs",
        int'(rec_data[idx[7:0]][IN_W-1:0]), int'(epins));
    chk(int'(rec_data[idx[7:0]][REC_W-1:IN_W]) == exp_ts(ecyc), req, "record timestamp",
        int'(rec_data[idx[7:0]][REC_W-1:IN_W]), exp_ts(ecyc));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    tick(3);
    chk(!active_o && !fifo_we_o && !overflow_o, "R1", "outputs in reset",
        int'({active_o, fifo_we_o, overflow_o}), 0);
    rst = 1'b0;
    tick(1);
    chk(!active_o && !fifo_we_o && !overflow_o, "R1", "outputs after reset",
        int'({active_o, fifo_we_o, overflow_o}), 0);
  endtask

  task automatic t_start(input logic [IN_W-1:0] p);
    int base;
    pins_i = p;
    tick(4);
    base = rec_tot;
    start_i = 1'b1;
    tick(1);
    start_i = 1'b0;
    c0 = cyc;
    chk(active_o == 1'b1, "R2", "active after start", int'(active_o), 1);
    tick(2);
    chk(rec_tot - base == 1, "R3", "initial record count", rec_tot - base, 1);
    chk_rec(base, "R3", c0 + 1, p);
  endtask

  task automatic t_change(input logic [IN_W-1:0] p, input string req);
    int base, cp;
    base = rec_tot;
    pins_i = p;
    cp = cyc;
    tick(4);
    chk(rec_tot - base == 1, req, "change record count", rec_tot - base, 1);
    chk_rec(base, req, cp + 3, p);
  endtask

  task automatic t_stable;
    int base;
    base = rec_tot;
    tick(20);
    chk(rec_tot == base, "R5", "records while stable", rec_tot - base, 0);
  endtask

  task automatic t_bounce;
    int base, cp;
    logic [IN_W-1:0] seq [0:3];
    base = rec_tot;
    cp = cyc;
    for (int i = 0; i < 4; i++) begin
      pins_i[3] = ~pins_i[3];
      seq[i] = pins_i;
      tick(1);
    end
    tick(4);
    chk(rec_tot - base == 4, "R6", "bounce record count", rec_tot - base, 4);
    for (int i = 0; i < 4; i++) chk_rec(base + i, "R6", cp + 3 + i, seq[i]);
  endtask

  task automatic t_restart;
    int base;
    base = rec_tot;
    start_i = 1'b1;
    tick(1);
    start_i = 1'b0;
    tick(3);
    chk(rec_tot == base, "R8", "no record from restart", rec_tot - base, 0);
    t_change(7'h41, "R8");
  endtask

  task automatic t_overflow;
    int base;
    chk(overflow_o == 1'b0, "R9", "overflow clear before", int'(overflow_o), 0);
    base = rec_tot;
    fifo_full_i = 1'b1;
    pins_i = 7'h22;
    tick(4);
    chk(rec_tot == base, "R9", "dropped record", rec_tot - base, 0);
    chk(overflow_o == 1'b1, "R9", "overflow set", int'(overflow_o), 1);
    fifo_full_i = 1'b0;
    tick(5);
    chk(overflow_o == 1'b1, "R9", "overflow sticky", int'(overflow_o), 1);
  endtask

  task automatic t_wrap;
    while (cyc < c0 + 300) tick(1);
    t_change(7'h5A, "R7");
  endtask

  task automatic t_end;
    int base;
    while (cyc < c0 + WIN_LEN - 1) tick(1);
    chk(active_o == 1'b1, "R2", "active on last cycle", int'(active_o), 1);
    tick(1);
    chk(active_o == 1'b0, "R2", "active after window", int'(active_o), 0);
    base = rec_tot;
    pins_i = 7'h0F;
    tick(6);
    chk(rec_tot == base, "R10", "records after window", rec_tot - base, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_start(7'h15);
    t_change(7'h14, "R4");
    t_stable();
    t_bounce();
    t_restart();
    t_overflow();
    t_wrap();
    t_end();
    t_start(7'h33);   // R2, R3: a second window restarts the timestamp at zero
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule